// File: doc/BRIEF.md
# Card Status Change Interrupt Controller

This block watches the status pins of one removable-card socket: a two-bit card-detect pair, a ready line, a two-bit battery-voltage pair, and a status-change line that an I/O card uses. Every pin passes through a synchroniser. A change seen on a pin sets a sticky flag in a four-bit change register. Software reads that register and learns which conditions moved. The read also empties the register.

Each flag has its own enable bit. The enabled flags are merged into one management interrupt, which runs in level or pulse mode. A four-bit routing code then steers the interrupt to one of sixteen system interrupt lines. The encoding is sparse, and some codes drive nothing. A small register port lets software program the block and read the socket status.

The meaning of the two battery flags depends on the card type. For a memory card they report battery-warning and battery-dead changes. For an I/O card the ready and warning flags are held at zero, and the lowest flag reports changes of the status-change line.

Top module: `card_evt_irq`

## Requirements
- R1: Reading address 0 returns the synchronised socket status, two clocks after the pins change. The layout is bits 1:0 card-detect pair, bit 2 ready, bits 4:3 battery pair and bit 5 status-change line. Bit 7 reads as 0. A write to address 0 has no effect.
- R2: Bit 6 of address 0 is 1 only when the synchronised card-detect pair is 11. Any change of either detect bit sets change flag bit 3.
- R3: In memory-card mode, control bit 0 is 0. A change of the ready line sets flag bit 2. Entering or leaving battery value 01 (warning) sets flag bit 1. Entering or leaving the data-lost values 00 and 10 sets flag bit 0. Battery value 11 means OK.
- R4: In I/O-card mode, control bit 0 is 1. A change of the status-change line sets flag bit 0. Flag bits 2 and 1 read 0 and stay 0, so ready and battery changes set nothing.
- R5: Address 1 returns the flags in bits 3:0 and zero in bits 7:4. A read strobe on address 1 clears every flag at that clock edge. Writes to address 1 are ignored.
- R6: A change event in the same cycle as a clearing read leaves its flag set after the read.
- R7: Address 2 is read/write. Bits 3:0 enable the flag at the same position into the management interrupt, and bits 7:4 hold the routing code.
- R8: In level mode (control bit 1 = 0), the management interrupt is high exactly while any enabled flag is set.
- R9: In pulse mode (control bit 1 = 1), the management interrupt is high for one clock after the OR of the enabled flags rises.
- R10: Routing codes 3, 4, 5, 7, 9, 10, 11, 12, 14 and 15 drive the interrupt onto the output line with the same index. Code 0 and the reserved codes 1, 2, 6, 8 and 13 drive no line.
- R11: Address 3 is read/write on bits 1:0 and reads 0 in bits 7:2.
- R12: After reset every register, flag and output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| det_i | input | 2 | Card-detect pair |
| rdy_i | input | 1 | Memory-card ready line |
| bvd_i | input | 2 | Battery-voltage pair |
| stschg_i | input | 1 | I/O-card status-change line |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe; clears the change flags at address 1 |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the current address |
| mgmt_irq_o | output | 1 | Management interrupt before routing |
| irq_o | output | 16 | Routed system interrupt lines |

## Verification
The bench builds the block with the default parameters: two synchroniser stages, sixteen interrupt lines and the sparse usable-line mask. This puts every one of the sixteen routing codes in reach, including each reserved code. A behavioural model records the pin history, and on every clock it predicts the read data, the management interrupt and all sixteen lines. Directed passes cover the detect, battery and ready transitions in both card modes, clearing reads placed at each offset from a pin change, and pulse mode. A pseudo-random pass then mixes pin changes, reads and writes.

// File: rtl/card_evt_pkg.sv
package card_evt_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned FLAG_W = 4;

  localparam logic [1:0] REG_STAT = 2'd0;
  localparam logic [1:0] REG_CHG  = 2'd1;
  localparam logic [1:0] REG_CFG  = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

  localparam int unsigned FLG_DET   = 3;
  localparam int unsigned FLG_RDY   = 2;
  localparam int unsigned FLG_BWARN = 1;
  localparam int unsigned FLG_BDEAD = 0;

  typedef struct packed {
    logic       stschg;
    logic [1:0] bvd;
    logic       rdy;
    logic [1:0] det;
  } sock_st_t;

  localparam int unsigned SOCK_W = $bits(sock_st_t);

  function automatic logic batt_warn(input logic [1:0] v);
    return v == 2'b01;
  endfunction

  function automatic logic batt_dead(input logic [1:0] v);
    return !v[0];
  endfunction
endpackage

// File: rtl/card_evt_sync.sv
module card_evt_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/card_evt_detect.sv
module card_evt_detect
  import card_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sock_st_t          cur_i,
  input  logic              io_mode_i,
  output logic [FLAG_W-1:0] evt_o
);
  sock_st_t prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur_i;
  end

  always_comb begin
    evt_o          = '0;
    evt_o[FLG_DET] = cur_i.det != prev_q.det;
    if (io_mode_i) begin
      evt_o[FLG_BDEAD] = cur_i.stschg != prev_q.stschg;
    end else begin
      evt_o[FLG_RDY]   = cur_i.rdy != prev_q.rdy;
      evt_o[FLG_BWARN] = batt_warn(cur_i.bvd) != batt_warn(prev_q.bvd);
      evt_o[FLG_BDEAD] = batt_dead(cur_i.bvd) != batt_dead(prev_q.bvd);
    end
  end
endmodule

// File: rtl/card_evt_flags.sv
module card_evt_flags
  import card_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] evt_i,
  input  logic              clr_i,
  input  logic              io_mode_i,
  output logic [FLAG_W-1:0] flag_o
);
  logic [FLAG_W-1:0] flag_q, flag_d;

  always_comb begin
    flag_d = (clr_i ? '0 : flag_q) | evt_i;  // new event survives a clear
    if (io_mode_i) begin
      flag_d[FLG_RDY]   = 1'b0;
      flag_d[FLG_BWARN] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/card_evt_route.sv
module card_evt_route
  import card_evt_pkg::*;
#(
  parameter int unsigned           NUM_IRQ    = 16,
  parameter logic [NUM_IRQ-1:0]    IRQ_USABLE = 16'hDEB8,
  localparam int unsigned          ROUTE_W    = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FLAG_W-1:0]  flag_i,
  input  logic [FLAG_W-1:0]  en_i,
  input  logic               pulse_i,
  input  logic [ROUTE_W-1:0] code_i,
  output logic               mgmt_o,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic any_en, any_q;

  assign any_en = |(flag_i & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) any_q <= 1'b0;
    else         any_q <= any_en;
  end

  assign mgmt_o = pulse_i ? (any_en & ~any_q) : any_en;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    if (IRQ_USABLE[i]) begin : g_use
      assign irq_o[i] = mgmt_o & (code_i == ROUTE_W'(i));
    end else begin : g_rsv
      assign irq_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/card_evt_irq.sv
module card_evt_irq
  import card_evt_pkg::*;
#(
  parameter int unsigned        SYNC_STAGES = 2,
  parameter int unsigned        NUM_IRQ     = 16,
  parameter logic [NUM_IRQ-1:0] IRQ_USABLE  = 16'hDEB8,
  localparam int unsigned       ROUTE_W     = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         det_i,
  input  logic               rdy_i,
  input  logic [1:0]         bvd_i,
  input  logic               stschg_i,
  input  logic [1:0]         reg_addr_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               mgmt_irq_o,
  output logic [NUM_IRQ-1:0] irq_o
);
  sock_st_t              pins, sync_st;
  logic [FLAG_W-1:0]     evt, flag_q;
  logic [FLAG_W+ROUTE_W-1:0] cfg_q;
  logic                  io_mode_q, pulse_q;
  logic                  rd_clr;

  assign pins = '{stschg: stschg_i, bvd: bvd_i, rdy: rdy_i, det: det_i};

  card_evt_sync #(.WIDTH(SOCK_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (pins), .q_o (sync_st)
  );

  card_evt_detect u_det (
    .clk_i (clk_i), .rst_ni (rst_ni), .cur_i (sync_st),
    .io_mode_i (io_mode_q), .evt_o (evt)
  );

  assign rd_clr = reg_rd_i && (reg_addr_i == REG_CHG);

  card_evt_flags u_flags (
    .clk_i (clk_i), .rst_ni (rst_ni), .evt_i (evt), .clr_i (rd_clr),
    .io_mode_i (io_mode_q), .flag_o (flag_q)
  );

  card_evt_route #(.NUM_IRQ(NUM_IRQ), .IRQ_USABLE(IRQ_USABLE)) u_route (
    .clk_i (clk_i), .rst_ni (rst_ni), .flag_i (flag_q),
    .en_i (cfg_q[FLAG_W-1:0]), .pulse_i (pulse_q),
    .code_i (cfg_q[FLAG_W+:ROUTE_W]), .mgmt_o (mgmt_irq_o), .irq_o (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      io_mode_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == REG_CFG)  cfg_q <= reg_wdata_i[FLAG_W+ROUTE_W-1:0];
      if (reg_addr_i == REG_CTRL) begin
        io_mode_q <= reg_wdata_i[0];
        pulse_q   <= reg_wdata_i[1];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_STAT: reg_rdata_o = REG_W'({(sync_st.det == 2'b11), sync_st});
      REG_CHG:  reg_rdata_o = REG_W'(flag_q);
      REG_CFG:  reg_rdata_o = REG_W'(cfg_q);
      REG_CTRL: reg_rdata_o = REG_W'({pulse_q, io_mode_q});
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/card_evt_chk.sv
module card_evt_chk #(
  parameter int unsigned        NUM_IRQ    = 16,
  parameter logic [NUM_IRQ-1:0] IRQ_USABLE = 16'hDEB8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [3:0]         evt,
  input logic [3:0]         flag_q,
  input logic               rd_clr,
  input logic               io_mode_q,
  input logic               pulse_q,
  input logic [7:0]         cfg_q,
  input logic               mgmt_irq_o,
  input logic [NUM_IRQ-1:0] irq_o
);
  // R5: clearing read with no new event empties the flags
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr && evt == 4'd0) |=> (flag_q == 4'd0));

  // R6: an event is never lost, even on a clearing read
  a_r6_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != 4'd0) |=> ((flag_q & $past(evt)) == $past(evt)));

  // R4: I/O mode holds ready and warning flags at zero
  a_r4_io_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_mode_q |=> (flag_q[2:1] == 2'b00));

  // R9: pulse lasts a single clock
  a_r9_pulse_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q && mgmt_irq_o) |=> (!mgmt_irq_o || !pulse_q));

  // R10: at most one line, only when the interrupt is live
  a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o) && (irq_o == '0 || mgmt_irq_o));

  // R10: reserved or disabled code drives nothing
  a_r10_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !IRQ_USABLE[cfg_q[7:4]] |-> (irq_o == '0));
endmodule

bind card_evt_irq card_evt_chk #(.NUM_IRQ(NUM_IRQ), .IRQ_USABLE(IRQ_USABLE)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .evt (evt), .flag_q (flag_q),
  .rd_clr (rd_clr), .io_mode_q (io_mode_q), .pulse_q (pulse_q),
  .cfg_q (cfg_q), .mgmt_irq_o (mgmt_irq_o), .irq_o (irq_o)
);

// File: tb/sim_card_evt_irq.sv
module sim_card_evt_irq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  det_i = '0, bvd_i = '0;
  logic        rdy_i = 1'b0, stschg_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        mgmt_irq_o;
  logic [15:0] irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  card_evt_irq u0 (.*);

  always #5 clk_i = ~clk_i;

  // reference model
  logic [5:0] hist[$];
  logic [3:0] m_flags;
  logic [7:0] m_cfg;
  logic [1:0] m_ctrl;
  logic       m_anyq;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = '{6'd0, 6'd0, 6'd0};
      m_flags = '0; m_cfg = '0; m_ctrl = '0; m_anyq = 1'b0;
    end else begin
      logic [5:0] a, b;
      logic [3:0] ev, nf;
      a = hist[1]; b = hist[2]; ev = '0;
      ev[3] = a[1:0] != b[1:0];
      if (m_ctrl[0]) ev[0] = a[5] != b[5];
      else begin
        ev[2] = a[2] != b[2];
        ev[1] = (a[4:3] == 2'b01) != (b[4:3] == 2'b01);
        ev[0] = a[3] != b[3];
      end
      m_anyq = |(m_flags & m_cfg[3:0]);
      nf = ((reg_rd_i && reg_addr_i == 2'd1) ? 4'd0 : m_flags) | ev;
      if (m_ctrl[0]) nf[2:1] = 2'b00;
      m_flags = nf;
      if (reg_wr_i && reg_addr_i == 2'd2) m_cfg = reg_wdata_i;
      if (reg_wr_i && reg_addr_i == 2'd3) m_ctrl = reg_wdata_i[1:0];
      hist.push_front({stschg_i, bvd_i, rdy_i, det_i});
      void'(hist.pop_back());
    end
  end

  function automatic bit usable(input logic [3:0] c);
    case (c)
      4'd3, 4'd4, 4'd5, 4'd7, 4'd9, 4'd10, 4'd11, 4'd12, 4'd14, 4'd15: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      logic [7:0] er;
      logic any, em;
      logic [15:0] ei;
      case (reg_addr_i)
        2'd0: er = {1'b0, hist[1][1:0] == 2'b11, hist[1]};
        2'd1: er = {4'd0, m_flags};
        2'd2: er = m_cfg;
        default: er = {6'd0, m_ctrl};
      endcase
      any = |(m_flags & m_cfg[3:0]);
      em  = m_ctrl[1] ? (any && !m_anyq) : any;
      ei  = (em && usable(m_cfg[7:4])) ? (16'd1 << m_cfg[7:4]) : 16'd0;
      case (reg_addr_i)
        2'd0: chk("R1/R2 status", reg_rdata_o, er);
        2'd1: chk("R3/R4/R5/R6 change", reg_rdata_o, er);
        2'd2: chk("R7 config", reg_rdata_o, er);
        default: chk("R11 control", reg_rdata_o, er);
      endcase
      chk("R8/R9 mgmt", mgmt_irq_o, em);
      chk("R10 route", irq_o, ei);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk_i);
    #2;
    reg_wr_i = 1'b0; reg_rd_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    step();
  endtask

  task automatic rd(input logic [1:0] a);
    reg_addr_i = a; reg_rd_i = 1'b1;
    step();
  endtask

  task automatic pins(input logic [1:0] d, input logic r, input logic [1:0] bv, input logic s);
    det_i = d; rdy_i = r; bvd_i = bv; stschg_i = s;
  endtask

  initial begin
    #50000000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    #23 rst_ni = 1'b1;
    step();
    // R12: reset state
    reg_addr_i = 2'd2; #1 chk("R12 reset cfg", reg_rdata_o, 8'h00);
    chk("R12 reset irq", irq_o, 16'h0);
    // memory mode, all enables, line 5, level
    wr(2'd2, 8'h5F);
    reg_addr_i = 2'd0;
    pins(2'b01, 1'b0, 2'b11, 1'b0); step(4);
    pins(2'b11, 1'b0, 2'b11, 1'b0); step(4);
    #1 chk("R2 present", reg_rdata_o[6], 1'b1);
    chk("R8 level", mgmt_irq_o, 1'b1);
    rd(2'd1); step(2);
    // battery walk 11 -> 01 -> 00 -> 10 -> 11, ready toggles
    pins(2'b11, 1'b0, 2'b01, 1'b0); step(4); reg_addr_i = 2'd1; step(1); rd(2'd1);
    pins(2'b11, 1'b1, 2'b00, 1'b0); step(4); rd(2'd1);
    pins(2'b11, 1'b1, 2'b10, 1'b0); step(4); rd(2'd1);
    pins(2'b11, 1'b0, 2'b11, 1'b0); step(4); rd(2'd1);
    // R10: all routing codes with a pending flag
    pins(2'b10, 1'b0, 2'b11, 1'b0); step(4);
    for (int c = 0; c < 16; c++) begin
      wr(2'd2, {c[3:0], 4'hF}); step(1);
    end
    rd(2'd1);
    // R9: pulse mode
    wr(2'd3, 8'h02); wr(2'd2, 8'hE8);
    pins(2'b11, 1'b0, 2'b11, 1'b0); step(6); rd(2'd1);
    pins(2'b01, 1'b0, 2'b11, 1'b0); step(6); rd(2'd1);
    // R4: I/O mode
    wr(2'd3, 8'h01); wr(2'd2, 8'h3F); reg_addr_i = 2'd1;
    pins(2'b01, 1'b1, 2'b00, 1'b0); step(5);
    pins(2'b01, 1'b1, 2'b00, 1'b1); step(5);
    #1 chk("R4 io status flag", reg_rdata_o, 8'h01);
    step(1); rd(2'd1);
    // R6: clearing read at each offset from a pin edge
    for (int d = 0; d < 6; d++) begin
      stschg_i = ~stschg_i; step(d); rd(2'd1); step(1); reg_addr_i = 2'd1; step(4); rd(2'd1);
    end
    // R5: writes to status and change registers ignored
    wr(2'd1, 8'hFF); wr(2'd0, 8'hFF); reg_addr_i = 2'd1; step(1);
    #1 chk("R5 write ignored", reg_rdata_o, 8'h00);
    // random mix
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0) pins(lfsr[4:3], lfsr[5], lfsr[7:6], lfsr[8]);
      reg_addr_i = lfsr[10:9];
      if (lfsr[13:11] == 3'd1) begin reg_wr_i = 1'b1; reg_wdata_i = {lfsr[7:0]}; end
      else if (lfsr[13:11] == 3'd2) reg_rd_i = 1'b1;
      step();
    end
    step(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule